// File: doc/BRIEF.md
# Per-Channel Calibration Request Sequencer

This block sits in the digital back end of a multi-channel converter and decides, for each finished conversion, whether the result is an ordinary sample or a calibration measurement. Eight logical channels are visited in a fixed round-robin order, one step per conversion-done pulse. Each logical channel owns a control byte. The byte holds a two-bit mode field and the physical input that the logical channel is wired to. A host writes and reads these bytes over a plain register port.

A host marks a calibration by writing a calibration mode into a channel's byte. Nothing happens until the scan next reaches that channel. On that visit the conversion result goes into the coefficient memory for the requested kind, at the entry of the mapped physical input. The result does not go to the sample output. In the same cycle the sequencer sets the mode field back to normal conversion. Coefficients are indexed by physical input, so logical channels that map to one input share one set of coefficients.

Top module: `cal_sequencer`

## Requirements
- R1: After reset every control byte reads 0x00, `scan_ch` is 0, `dat_valid` is low, and every coefficient entry reads 0.
- R2: A host write stores bits [1:0] as the mode and bits [4:2] as the physical input of the addressed byte. Readback returns these fields in the same positions. Bits [7:5] always read 0.
- R3: `scan_ch` advances by one on each cycle with `conv_done` high and wraps from 7 to 0. Without `conv_done` it holds its value.
- R4: When the scanned channel's mode is 00 (convert), the cycle after `conv_done` shows `dat_valid` high, `dat_ch` equal to the scanned channel and `dat_value` equal to `conv_result`. No coefficient changes.
- R5: When the scanned channel's mode is calibration, the result is written to a coefficient memory: 01 selects offset, 10 selects positive full scale and 11 selects negative full scale. The entry used is the channel's physical input. `dat_valid` stays low in the following cycle.
- R6: After a calibration visit, the channel's mode field reads 00 and its physical input field is unchanged.
- R7: Writing a calibration mode changes no coefficient until the scan visits that logical channel.
- R8: If a host write to a channel lands in the same cycle as that channel's automatic clear, the written byte is kept.
- R9: Logical channels that map to the same physical input share coefficient entries. The most recent calibration overwrites the earlier one.
- R10: `dat_valid` is a one-cycle pulse. It is high only in the cycle after a `conv_done` that found the channel in mode 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Host write strobe for a control byte |
| cfg_addr | input | 3 | Logical channel addressed by the write |
| cfg_wdata | input | 8 | Control byte to write |
| cfg_rd_addr | input | 3 | Logical channel addressed by the read |
| cfg_rdata | output | 8 | Control byte readback |
| conv_done | input | 1 | Conversion for the scanned channel finished |
| conv_result | input | 16 | Corrected conversion result |
| scan_ch | output | 3 | Logical channel currently being converted |
| dat_valid | output | 1 | Sample output strobe |
| dat_ch | output | 3 | Logical channel of the sample |
| dat_value | output | 16 | Sample value |
| coef_rd_kind | input | 2 | Coefficient kind to read (01, 10, 11; 00 reads zero) |
| coef_rd_pch | input | 3 | Physical input to read |
| coef_rdata | output | 16 | Coefficient readback |

## Verification
The hardest case to reach is R8. A host write to a channel must land in exactly the cycle in which the scan is clearing that same channel's calibration request. From the ports this means steering the pointer to that channel with a calibration pending, then raising `conv_done` and `cfg_wr_en` together. A directed sequence sets this up on purpose. The random phase reaches it again by chance, because it mixes frequent conversion pulses with host writes to random channels. The bench's reference model applies the clear before the host write, and full readbacks then show which value survived.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
   localparam int MODE_W  = 2;
   localparam int N_KINDS = 3;

   typedef enum logic [MODE_W-1:0] {
      MODE_CONV = 2'b00,
      MODE_OFFS = 2'b01,
      MODE_PFS  = 2'b10,
      MODE_NFS  = 2'b11
   } cal_mode_e;

   function automatic logic mode_is_cal(input cal_mode_e m);
      return m != MODE_CONV;
   endfunction
endpackage

// File: rtl/cal_ctrl_regfile.sv
module cal_ctrl_regfile
   import cal_seq_pkg::*;
#(
   parameter int N_LCH  = 8,
   parameter int PCH_W  = 3,
   parameter int CTRL_W = 8,
   localparam int LCH_W = $clog2(N_LCH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [LCH_W-1:0]        wr_addr,
   input  logic [CTRL_W-1:0]       wr_data,
   input  logic                    clr_en,
   input  logic [LCH_W-1:0]        clr_addr,
   input  logic [LCH_W-1:0]        rd_addr,
   output logic [CTRL_W-1:0]       rd_data,
   input  logic [LCH_W-1:0]        scan_addr,
   output cal_mode_e               scan_mode,
   output logic [PCH_W-1:0]        scan_pch,
   output logic [N_LCH*CTRL_W-1:0] ctrl_flat
);
   cal_mode_e        mode_q [N_LCH];
   logic [PCH_W-1:0] pch_q  [N_LCH];

   for (genvar i = 0; i < N_LCH; i++) begin : g_lch
      logic hit_wr, hit_clr;
      assign hit_wr  = wr_en  && (wr_addr  == LCH_W'(i));
      assign hit_clr = clr_en && (clr_addr == LCH_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mode_q[i] <= MODE_CONV;
            pch_q[i]  <= '0;
         end else if (hit_wr) begin
            // host write outranks the automatic clear
            mode_q[i] <= cal_mode_e'(wr_data[MODE_W-1:0]);
            pch_q[i]  <= wr_data[MODE_W +: PCH_W];
         end else if (hit_clr) begin
            mode_q[i] <= MODE_CONV;
         end
      end

      always_comb begin
         ctrl_flat[i*CTRL_W +: CTRL_W]          = '0;
         ctrl_flat[i*CTRL_W +: MODE_W]          = mode_q[i];
         ctrl_flat[i*CTRL_W + MODE_W +: PCH_W]  = pch_q[i];
      end
   end

   always_comb begin
      rd_data                 = '0;
      rd_data[MODE_W-1:0]     = mode_q[rd_addr];
      rd_data[MODE_W +: PCH_W] = pch_q[rd_addr];
   end

   assign scan_mode = mode_q[scan_addr];
   assign scan_pch  = pch_q[scan_addr];
endmodule

// File: rtl/cal_scan_ptr.sv
module cal_scan_ptr #(
   parameter int N_LCH  = 8,
   localparam int LCH_W = $clog2(N_LCH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [LCH_W-1:0] ptr
);
   logic [LCH_W-1:0] nxt;

   if ((1 << LCH_W) == N_LCH) begin : g_pow2
      assign nxt = ptr + LCH_W'(1);
   end else begin : g_wrap
      assign nxt = (ptr == LCH_W'(N_LCH - 1)) ? '0 : ptr + LCH_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    ptr <= '0;
      else if (step) ptr <= nxt;
   end
endmodule

// File: rtl/cal_mode_decode.sv
module cal_mode_decode
   import cal_seq_pkg::*;
(
   input  logic      fire,
   input  cal_mode_e mode,
   output logic      to_data,
   output logic      to_coef
);
   always_comb begin
      to_data = 1'b0;
      to_coef = 1'b0;
      if (fire) begin
         unique case (mode)
            MODE_CONV:                     to_data = 1'b1;
            MODE_OFFS, MODE_PFS, MODE_NFS: to_coef = 1'b1;
            default:                       to_data = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/cal_coef_bank.sv
module cal_coef_bank
   import cal_seq_pkg::*;
#(
   parameter int N_PCH  = 8,
   parameter int DATA_W = 16,
   localparam int PCH_W = $clog2(N_PCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  cal_mode_e         wkind,
   input  logic [PCH_W-1:0]  wpch,
   input  logic [DATA_W-1:0] wdata,
   input  logic [MODE_W-1:0] rkind,
   input  logic [PCH_W-1:0]  rpch,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] kind_rd [N_KINDS];

   for (genvar k = 0; k < N_KINDS; k++) begin : g_kind
      localparam logic [MODE_W-1:0] KCODE = MODE_W'(k + 1);
      logic [DATA_W-1:0] mem [N_PCH];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int p = 0; p < N_PCH; p++) mem[p] <= '0;
         end else if (we && (wkind == cal_mode_e'(KCODE))) begin
            mem[wpch] <= wdata;
         end
      end

      assign kind_rd[k] = mem[rpch];
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < N_KINDS; k++)
         if (rkind == MODE_W'(k + 1)) rdata = kind_rd[k];
   end
endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer
   import cal_seq_pkg::*;
#(
   parameter int N_LCH  = 8,
   parameter int N_PCH  = 8,
   parameter int DATA_W = 16,
   parameter int CTRL_W = 8,
   localparam int LCH_W = $clog2(N_LCH),
   localparam int PCH_W = $clog2(N_PCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [LCH_W-1:0]  cfg_addr,
   input  logic [CTRL_W-1:0] cfg_wdata,
   input  logic [LCH_W-1:0]  cfg_rd_addr,
   output logic [CTRL_W-1:0] cfg_rdata,
   input  logic              conv_done,
   input  logic [DATA_W-1:0] conv_result,
   output logic [LCH_W-1:0]  scan_ch,
   output logic              dat_valid,
   output logic [LCH_W-1:0]  dat_ch,
   output logic [DATA_W-1:0] dat_value,
   input  logic [MODE_W-1:0] coef_rd_kind,
   input  logic [PCH_W-1:0]  coef_rd_pch,
   output logic [DATA_W-1:0] coef_rdata
);
   if (N_LCH < 2) begin : g_bad_lch
      $error("cal_sequencer: N_LCH must be at least 2");
   end
   if (N_PCH < 2) begin : g_bad_pch
      $error("cal_sequencer: N_PCH must be at least 2");
   end
   if (CTRL_W < MODE_W + PCH_W) begin : g_bad_ctrl
      $error("cal_sequencer: CTRL_W too narrow for mode and physical fields");
   end

   cal_mode_e               cur_mode;
   logic [PCH_W-1:0]        cur_pch;
   logic                    go_data, go_coef;
   logic [N_LCH*CTRL_W-1:0] ctrl_flat;

   cal_scan_ptr #(.N_LCH(N_LCH)) u_ptr (
      .clk  (clk),
      .rst_n(rst_n),
      .step (conv_done),
      .ptr  (scan_ch)
   );

   cal_ctrl_regfile #(.N_LCH(N_LCH), .PCH_W(PCH_W), .CTRL_W(CTRL_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_wr_en),
      .wr_addr  (cfg_addr),
      .wr_data  (cfg_wdata),
      .clr_en   (go_coef),
      .clr_addr (scan_ch),
      .rd_addr  (cfg_rd_addr),
      .rd_data  (cfg_rdata),
      .scan_addr(scan_ch),
      .scan_mode(cur_mode),
      .scan_pch (cur_pch),
      .ctrl_flat(ctrl_flat)
   );

   cal_mode_decode u_dec (
      .fire   (conv_done),
      .mode   (cur_mode),
      .to_data(go_data),
      .to_coef(go_coef)
   );

   cal_coef_bank #(.N_PCH(N_PCH), .DATA_W(DATA_W)) u_coef (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (go_coef),
      .wkind(cur_mode),
      .wpch (cur_pch),
      .wdata(conv_result),
      .rkind(coef_rd_kind),
      .rpch (coef_rd_pch),
      .rdata(coef_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dat_valid <= 1'b0;
         dat_ch    <= '0;
         dat_value <= '0;
      end else begin
         dat_valid <= go_data;
         if (go_data) begin
            dat_ch    <= scan_ch;
            dat_value <= conv_result;
         end
      end
   end
endmodule

// File: rtl/cal_sequencer_chk.sv
module cal_sequencer_chk #(
   parameter int N_LCH  = 8,
   parameter int PCH_W  = 3,
   parameter int CTRL_W = 8,
   localparam int LCH_W = $clog2(N_LCH)
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    conv_done,
   input logic                    cfg_wr_en,
   input logic [LCH_W-1:0]        cfg_addr,
   input logic [CTRL_W-1:0]       cfg_wdata,
   input logic [LCH_W-1:0]        scan_ch,
   input logic                    dat_valid,
   input logic [1:0]              cur_mode,
   input logic [N_LCH*CTRL_W-1:0] ctrl_flat
);
   localparam logic [CTRL_W-1:0] KEEP = CTRL_W'((1 << (2 + PCH_W)) - 1);
   localparam logic [LCH_W-1:0]  LAST = LCH_W'(N_LCH - 1);

   // R3
   scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |=> scan_ch == (($past(scan_ch) == LAST) ? '0 : $past(scan_ch) + LCH_W'(1)));

   // R3
   scan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_done |=> $stable(scan_ch));

   // R10
   strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dat_valid |-> $past(conv_done) && ($past(cur_mode) == 2'b00));

   // R5
   cal_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && cur_mode != 2'b00) |=> !dat_valid);

   // R6
   cal_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && cur_mode != 2'b00 && !(cfg_wr_en && cfg_addr == scan_ch))
      |=> ctrl_flat[$past(scan_ch)*CTRL_W +: 2] == 2'b00);

   // R8
   host_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_en |=> ctrl_flat[$past(cfg_addr)*CTRL_W +: CTRL_W] == ($past(cfg_wdata) & KEEP));
endmodule

bind cal_sequencer cal_sequencer_chk #(.N_LCH(N_LCH), .PCH_W(PCH_W), .CTRL_W(CTRL_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .conv_done(conv_done),
   .cfg_wr_en(cfg_wr_en),
   .cfg_addr (cfg_addr),
   .cfg_wdata(cfg_wdata),
   .scan_ch  (scan_ch),
   .dat_valid(dat_valid),
   .cur_mode (cur_mode),
   .ctrl_flat(ctrl_flat)
);

// File: tb/sim_cal_sequencer.sv
module sim_cal_sequencer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic [2:0]  cfg_rd_addr = '0;
   logic [7:0]  cfg_rdata;
   logic        conv_done = 1'b0;
   logic [15:0] conv_result = '0;
   logic [2:0]  scan_ch;
   logic        dat_valid;
   logic [2:0]  dat_ch;
   logic [15:0] dat_value;
   logic [1:0]  coef_rd_kind = '0;
   logic [2:0]  coef_rd_pch = '0;
   logic [15:0] coef_rdata;

   int n_cmp = 0;
   int n_bad = 0;

   logic [7:0]  m_ctrl [8];
   logic [15:0] m_coef [4][8];
   logic [2:0]  m_ptr;

   always #10 clk = ~clk;

   cal_sequencer u0 (.*);

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic wr, input logic [2:0] wa, input logic [7:0] wd,
                       input logic dn, input logic [15:0] res);
      logic [1:0] md;
      logic       ev;
      logic [2:0] ec;
      @(negedge clk);
      cfg_wr_en = wr; cfg_addr = wa; cfg_wdata = wd;
      conv_done = dn; conv_result = res;
      ev = 1'b0; ec = m_ptr;
      if (dn) begin
         md = m_ctrl[m_ptr][1:0];
         if (md == 2'b00) ev = 1'b1;
         else begin
            m_coef[md][m_ctrl[m_ptr][4:2]] = res;
            m_ctrl[m_ptr][1:0] = 2'b00;
         end
         m_ptr = m_ptr + 3'd1;
      end
      if (wr) m_ctrl[wa] = wd & 8'h1F;
      @(posedge clk);
      #2;
      check("R5/R10 dat_valid", {31'd0, dat_valid}, {31'd0, ev});
      if (ev) begin
         check("R4 dat_ch", {29'd0, dat_ch}, {29'd0, ec});
         check("R4 dat_value", {16'd0, dat_value}, {16'd0, res});
      end
      check("R3 scan_ch", {29'd0, scan_ch}, {29'd0, m_ptr});
      cfg_wr_en = 1'b0; conv_done = 1'b0;
   endtask

   task automatic full_compare(input string tag);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); cfg_rd_addr = 3'(i); #2;
         check({tag, " R2/R6 ctrl"}, {24'd0, cfg_rdata}, {24'd0, m_ctrl[i]});
      end
      for (int k = 0; k < 4; k++)
         for (int p = 0; p < 8; p++) begin
            @(negedge clk); coef_rd_kind = 2'(k); coef_rd_pch = 3'(p); #2;
            check({tag, " R5/R9 coef"}, {16'd0, coef_rdata}, {16'd0, m_coef[k][p]});
         end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int unused;
      unused = $urandom(32'd4242);
      for (int i = 0; i < 8; i++) m_ctrl[i] = '0;
      for (int k = 0; k < 4; k++) for (int p = 0; p < 8; p++) m_coef[k][p] = '0;
      m_ptr = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #2;
      check("R1 scan_ch", {29'd0, scan_ch}, 32'd0);
      check("R1 dat_valid", {31'd0, dat_valid}, 32'd0);
      full_compare("R1 reset");

      // R4: plain conversions on channels 0..2
      step(0, 0, 0, 1, 16'h1234);
      step(0, 0, 0, 1, 16'hFFFF);
      step(0, 0, 0, 0, 16'h0);
      step(0, 0, 0, 1, 16'h0000);

      // R7: pending negative-full-scale request on ch 6 (mode 11, pch 5)
      step(1, 3'd6, 8'h17, 0, 16'h0);
      step(0, 0, 0, 0, 16'h0);
      full_compare("R7 pending");
      step(0, 0, 0, 1, 16'h0AAA);   // ch3
      step(0, 0, 0, 1, 16'h0BBB);   // ch4
      step(0, 0, 0, 1, 16'h0CCC);   // ch5
      step(0, 0, 0, 1, 16'h8001);   // ch6 calibrates
      full_compare("R5/R6 after cal");

      // R8: ch7 has offset request, host rewrites it in the clearing cycle
      step(1, 3'd7, 8'h05, 0, 16'h0);
      step(1, 3'd7, 8'hEA, 1, 16'h7FFE);
      full_compare("R8 collide");

      // R9: ch1 and ch2 both map pch 2 with positive full scale
      step(1, 3'd1, 8'h0A, 1, 16'h0101);   // ch0 converts
      step(1, 3'd2, 8'h0A, 1, 16'h2222);   // ch1 calibrates
      step(0, 0, 0, 1, 16'h3333);          // ch2 calibrates, same entry
      full_compare("R9 shared");

      // random phase
      for (int n = 0; n < 3000; n++) begin
         step(($urandom % 6) == 0, 3'($urandom), 8'($urandom),
              ($urandom % 2) == 0, 16'($urandom));
         if (n % 300 == 299) full_compare("random");
      end
      full_compare("final");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule